// File: doc/BRIEF.md
# Fused Multiply-Add NaN Result Selector

This unit decides which NaN a fused multiply-add `(a*b)+c` returns when any of its three operands is a NaN, or when the product is infinity times zero. It classifies each operand as a quiet NaN, a signalling NaN or neither. It then applies one of three run-time priority policies and produces three outputs: a 2-bit choice code, the final result word and the invalid-operation flag. A signalling NaN that is picked always leaves the unit quiet. A default-NaN mode replaces the picked value with the canonical quiet NaN of the format, and the invalid flag is still raised.

The unit handles single precision in the low 32 bits of a 64-bit word and double precision across the whole word. The multiply-add arithmetic sits outside it. The core logic is combinational, and one register stage holds the outputs, so a result appears on the outputs one clock after its operands are presented. When no operand is a NaN and the infinity-times-zero flag is clear, the outputs have no defined meaning.

Top module: `fma_nan_sel`

## Requirements
- R1: Choice codes are 0 = a, 1 = b, 2 = c and 3 = default NaN. For codes 0 to 2, with default mode off, the result is the chosen operand with its quiet bit set. The quiet bit is bit 22 for single (exponent bits 30:23, fraction 22:0) and bit 51 for double (exponent 62:52, fraction 51:0).
- R2: The invalid flag is set whenever any operand is a signalling NaN, meaning all-ones exponent, quiet bit clear and nonzero fraction.
- R3: Under policy 0, when infinity-times-zero is set and c is a quiet NaN, the choice is 3 and invalid is set.
- R4: Otherwise, policy 0 takes the first match in this order: c signalling, a signalling, b signalling, c quiet, a quiet, and else b.
- R5: Under policy 1, infinity-times-zero gives choice 3 with invalid set.
- R6: Otherwise, policy 1 takes the first match in this order: a signalling, b signalling, c signalling, a quiet, b quiet, and else c.
- R7: Under policy 2, infinity-times-zero gives choice 2 with invalid set.
- R8: Otherwise, policy 2 takes a if a is any NaN, else c if c is any NaN, else b.
- R9: In default mode the choice code and the invalid flag are unchanged, and the result is the default NaN of the format.
- R10: The default NaNs are 0x7FC00000 for single and 0x7FF8000000000000 for double. Single results have bits 63:32 at zero, and bits 63:32 of single operands are ignored.
- R11: Policy code 3 behaves exactly like policy 0.
- R12: Outputs are registered with one cycle of latency, and an active-low asynchronous reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 64 | Multiplicand a |
| op_b | input | 64 | Multiplier b |
| op_c | input | 64 | Addend c |
| prod_inf_zero | input | 1 | Product a*b was infinity times zero |
| policy_sel | input | 2 | Priority policy (0, 1, 2; 3 behaves as 0) |
| fmt_dbl | input | 1 | 1 = double, 0 = single in the low 32 bits |
| dflt_mode | input | 1 | Force the default NaN result |
| pick_code | output | 2 | Choice code |
| nan_result | output | 64 | Quieted or default NaN result |
| invalid_flag | output | 1 | Invalid-operation flag |

## Verification
The bench targets the following corner cases:

- **Policy 0 with infinity-times-zero and a signalling c.** The special case must not fire here. A design that fires on any NaN in c would return the default NaN instead of quieted c.
- **Several signalling NaNs under each policy.** This exposes a priority order that has been rotated or copied from another policy.
- **Default mode with a signalling input.** A design that drops the invalid flag, or forces the choice code to 3, fails this case.
- **Single-precision operands with junk in the upper word.** A design that classifies on the full width or forwards the upper bits fails this case.
- **Infinity bit patterns next to NaNs.** This catches a NaN test that accepts a zero fraction.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;

   typedef enum logic [1:0] {
      CH_A    = 2'd0,
      CH_B    = 2'd1,
      CH_C    = 2'd2,
      CH_DFLT = 2'd3
   } nan_choice_e;

   typedef enum logic [1:0] {
      POL_C_FIRST   = 2'd0,
      POL_A_FIRST   = 2'd1,
      POL_A_THEN_C  = 2'd2,
      POL_SPARE     = 2'd3
   } nan_policy_e;

   typedef struct packed {
      logic is_nan;
      logic is_snan;
      logic is_qnan;
   } nan_class_t;

endpackage

// File: rtl/fnan_classify.sv
module fnan_classify
   import fma_nan_pkg::*;
#(
   parameter int FLEN   = 64,
   parameter int SP_EXP = 8,
   parameter int SP_MAN = 23,
   parameter int DP_EXP = 11,
   parameter int DP_MAN = 52
) (
   input  logic [FLEN-1:0] word,
   input  logic            fmt_dbl,
   output nan_class_t      cls
);
   localparam int SP_W = 1 + SP_EXP + SP_MAN;
   localparam int DP_W = 1 + DP_EXP + DP_MAN;

   logic sp_exp_ones, dp_exp_ones, sp_frac_nz, dp_frac_nz, sp_q, dp_q;
   logic exp_ones, frac_nz, qbit;

   assign sp_exp_ones = &word[SP_W-2:SP_MAN];
   assign dp_exp_ones = &word[DP_W-2:DP_MAN];
   assign sp_frac_nz  = |word[SP_MAN-1:0];
   assign dp_frac_nz  = |word[DP_MAN-1:0];
   assign sp_q        = word[SP_MAN-1];
   assign dp_q        = word[DP_MAN-1];

   assign exp_ones = fmt_dbl ? dp_exp_ones : sp_exp_ones;
   assign frac_nz  = fmt_dbl ? dp_frac_nz  : sp_frac_nz;
   assign qbit     = fmt_dbl ? dp_q        : sp_q;

   always_comb begin
      cls.is_nan  = exp_ones & frac_nz;
      cls.is_qnan = exp_ones & qbit;
      cls.is_snan = exp_ones & frac_nz & ~qbit;
   end
endmodule

// File: rtl/fnan_priority.sv
module fnan_priority
   import fma_nan_pkg::*;
(
   input  nan_class_t  cls_a,
   input  nan_class_t  cls_b,
   input  nan_class_t  cls_c,
   input  logic        inf_zero,
   input  nan_policy_e policy,
   output nan_choice_e choice,
   output logic        iz_invalid
);
   always_comb begin
      choice     = CH_B;
      iz_invalid = 1'b0;
      unique case (policy)
         POL_A_FIRST: begin
            if (inf_zero) begin
               choice     = CH_DFLT;
               iz_invalid = 1'b1;
            end
            else if (cls_a.is_snan) choice = CH_A;
            else if (cls_b.is_snan) choice = CH_B;
            else if (cls_c.is_snan) choice = CH_C;
            else if (cls_a.is_qnan) choice = CH_A;
            else if (cls_b.is_qnan) choice = CH_B;
            else                    choice = CH_C;
         end
         POL_A_THEN_C: begin
            if (inf_zero) begin
               choice     = CH_C;
               iz_invalid = 1'b1;
            end
            else if (cls_a.is_nan) choice = CH_A;
            else if (cls_c.is_nan) choice = CH_C;
            else                   choice = CH_B;
         end
         POL_C_FIRST, POL_SPARE: begin
            if (inf_zero && cls_c.is_qnan) begin
               choice     = CH_DFLT;
               iz_invalid = 1'b1;
            end
            else if (cls_c.is_snan) choice = CH_C;
            else if (cls_a.is_snan) choice = CH_A;
            else if (cls_b.is_snan) choice = CH_B;
            else if (cls_c.is_qnan) choice = CH_C;
            else if (cls_a.is_qnan) choice = CH_A;
            else                    choice = CH_B;
         end
         default: choice = CH_B;
      endcase
   end
endmodule

// File: rtl/fnan_quieten.sv
module fnan_quieten #(
   parameter int FLEN   = 64,
   parameter int SP_EXP = 8,
   parameter int SP_MAN = 23,
   parameter int DP_EXP = 11,
   parameter int DP_MAN = 52
) (
   input  logic [FLEN-1:0] word,
   input  logic            fmt_dbl,
   output logic [FLEN-1:0] quiet_word,
   output logic [FLEN-1:0] dflt_word
);
   localparam int SP_W = 1 + SP_EXP + SP_MAN;
   localparam int DP_W = 1 + DP_EXP + DP_MAN;
   localparam logic [FLEN-1:0] SP_MASK = {FLEN{1'b1}} >> (FLEN - SP_W);
   localparam logic [FLEN-1:0] DP_MASK = {FLEN{1'b1}} >> (FLEN - DP_W);
   localparam logic [FLEN-1:0] SP_QB   = FLEN'(1) << (SP_MAN - 1);
   localparam logic [FLEN-1:0] DP_QB   = FLEN'(1) << (DP_MAN - 1);
   localparam logic [FLEN-1:0] SP_EXPM = (SP_MASK >> (SP_MAN + 1)) << SP_MAN;
   localparam logic [FLEN-1:0] DP_EXPM = (DP_MASK >> (DP_MAN + 1)) << DP_MAN;

   assign quiet_word = fmt_dbl ? ((word & DP_MASK) | DP_QB)
                               : ((word & SP_MASK) | SP_QB);
   assign dflt_word  = fmt_dbl ? (DP_EXPM | DP_QB) : (SP_EXPM | SP_QB);
endmodule

// File: rtl/fma_nan_sel.sv
module fma_nan_sel
   import fma_nan_pkg::*;
#(
   parameter int FLEN   = 64,
   parameter int SP_EXP = 8,
   parameter int SP_MAN = 23,
   parameter int DP_EXP = 11,
   parameter int DP_MAN = 52
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [FLEN-1:0] op_a,
   input  logic [FLEN-1:0] op_b,
   input  logic [FLEN-1:0] op_c,
   input  logic            prod_inf_zero,
   input  logic [1:0]      policy_sel,
   input  logic            fmt_dbl,
   input  logic            dflt_mode,
   output logic [1:0]      pick_code,
   output logic [FLEN-1:0] nan_result,
   output logic            invalid_flag
);
   localparam int NOPS = 3;
   localparam int SP_W = 1 + SP_EXP + SP_MAN;
   localparam int DP_W = 1 + DP_EXP + DP_MAN;

   if (DP_W > FLEN || SP_W > DP_W || SP_MAN < 2 || DP_MAN < 2) begin : g_bad_cfg
      initial $fatal(1, "fma_nan_sel: inconsistent format parameters");
   end

   logic [FLEN-1:0] ops [NOPS];
   nan_class_t      cls [NOPS];

   assign ops[0] = op_a;
   assign ops[1] = op_b;
   assign ops[2] = op_c;

   for (genvar g = 0; g < NOPS; g++) begin : g_cls
      fnan_classify #(
         .FLEN(FLEN), .SP_EXP(SP_EXP), .SP_MAN(SP_MAN),
         .DP_EXP(DP_EXP), .DP_MAN(DP_MAN)
      ) u_cls (
         .word    (ops[g]),
         .fmt_dbl (fmt_dbl),
         .cls     (cls[g])
      );
   end

   nan_choice_e     choice;
   logic            iz_invalid;
   logic            snan_seen;
   logic [FLEN-1:0] sel_word, quiet_word, dflt_word, result_nx;

   fnan_priority u_pri (
      .cls_a      (cls[0]),
      .cls_b      (cls[1]),
      .cls_c      (cls[2]),
      .inf_zero   (prod_inf_zero),
      .policy     (nan_policy_e'(policy_sel)),
      .choice     (choice),
      .iz_invalid (iz_invalid)
   );

   always_comb begin
      snan_seen = 1'b0;
      for (int i = 0; i < NOPS; i++) snan_seen |= cls[i].is_snan;
   end

   always_comb begin
      unique case (choice)
         CH_A:    sel_word = op_a;
         CH_B:    sel_word = op_b;
         default: sel_word = op_c;
      endcase
   end

   fnan_quieten #(
      .FLEN(FLEN), .SP_EXP(SP_EXP), .SP_MAN(SP_MAN),
      .DP_EXP(DP_EXP), .DP_MAN(DP_MAN)
   ) u_qt (
      .word       (sel_word),
      .fmt_dbl    (fmt_dbl),
      .quiet_word (quiet_word),
      .dflt_word  (dflt_word)
   );

   assign result_nx = (dflt_mode || choice == CH_DFLT) ? dflt_word : quiet_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pick_code    <= '0;
         nan_result   <= '0;
         invalid_flag <= 1'b0;
      end else begin
         pick_code    <= choice;
         nan_result   <= result_nx;
         invalid_flag <= snan_seen | iz_invalid;
      end
   end
endmodule

// File: rtl/fma_nan_sel_chk.sv
module fma_nan_sel_chk #(
   parameter int FLEN   = 64,
   parameter int SP_EXP = 8,
   parameter int SP_MAN = 23,
   parameter int DP_EXP = 11,
   parameter int DP_MAN = 52
) (
   input logic            clk,
   input logic            rst_n,
   input logic [FLEN-1:0] op_a,
   input logic [FLEN-1:0] op_b,
   input logic [FLEN-1:0] op_c,
   input logic            prod_inf_zero,
   input logic [1:0]      policy_sel,
   input logic            fmt_dbl,
   input logic            dflt_mode,
   input logic [1:0]      pick_code,
   input logic [FLEN-1:0] nan_result,
   input logic            invalid_flag
);
   localparam int SP_W = 1 + SP_EXP + SP_MAN;
   localparam int DP_W = 1 + DP_EXP + DP_MAN;
   localparam logic [FLEN-1:0] SP_D =
      FLEN'({1'b0, {SP_EXP{1'b1}}, 1'b1, {(SP_MAN-1){1'b0}}});
   localparam logic [FLEN-1:0] DP_D =
      FLEN'({1'b0, {DP_EXP{1'b1}}, 1'b1, {(DP_MAN-1){1'b0}}});

   function automatic logic [1:0] kind(input logic [FLEN-1:0] w, input logic dbl);
      logic e1, nz, q;
      if (dbl) begin
         e1 = (w[DP_W-2:DP_MAN] == {DP_EXP{1'b1}});
         nz = (w[DP_MAN-1:0] != '0);
         q  = w[DP_MAN-1];
      end else begin
         e1 = (w[SP_W-2:SP_MAN] == {SP_EXP{1'b1}});
         nz = (w[SP_MAN-1:0] != '0);
         q  = w[SP_MAN-1];
      end
      return {e1 && nz, e1 && nz && !q};
   endfunction

   logic [1:0] ka, kb, kc;
   logic any_nan, any_snan, armed;
   assign ka = kind(op_a, fmt_dbl);
   assign kb = kind(op_b, fmt_dbl);
   assign kc = kind(op_c, fmt_dbl);
   assign any_nan  = ka[1] | kb[1] | kc[1];
   assign any_snan = ka[0] | kb[0] | kc[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   p_snan_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(any_snan) |-> invalid_flag);

   p_iz_dflt_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(prod_inf_zero && policy_sel == 2'd1) |-> (pick_code == 2'd3 && invalid_flag));

   p_iz_addend_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(prod_inf_zero && policy_sel == 2'd2) |-> (pick_code == 2'd2 && invalid_flag));

   p_dflt_mode_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(dflt_mode && any_nan) |-> nan_result == ($past(fmt_dbl) ? DP_D : SP_D));

   p_code3_dflt_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (pick_code == 2'd3) |-> (nan_result == SP_D || nan_result == DP_D));

   p_quiet_out_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(any_nan && !fmt_dbl) |-> nan_result[SP_MAN-1] && nan_result[FLEN-1:SP_W] == '0);

   p_quiet_dbl_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(any_nan && fmt_dbl) |-> nan_result[DP_MAN-1]);
endmodule

bind fma_nan_sel fma_nan_sel_chk #(
   .FLEN(FLEN), .SP_EXP(SP_EXP), .SP_MAN(SP_MAN), .DP_EXP(DP_EXP), .DP_MAN(DP_MAN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_c(op_c),
   .prod_inf_zero(prod_inf_zero), .policy_sel(policy_sel), .fmt_dbl(fmt_dbl),
   .dflt_mode(dflt_mode), .pick_code(pick_code), .nan_result(nan_result),
   .invalid_flag(invalid_flag)
);

// File: tb/fma_nan_sel_tb_top.sv
module fma_nan_sel_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] op_a = '0, op_b = '0, op_c = '0;
   logic        prod_inf_zero = 1'b0;
   logic [1:0]  policy_sel = '0;
   logic        fmt_dbl = 1'b0;
   logic        dflt_mode = 1'b0;
   logic [1:0]  pick_code;
   logic [63:0] nan_result;
   logic        invalid_flag;

   int total = 0, bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fma_nan_sel dut_i (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_c(op_c),
      .prod_inf_zero(prod_inf_zero), .policy_sel(policy_sel), .fmt_dbl(fmt_dbl),
      .dflt_mode(dflt_mode), .pick_code(pick_code), .nan_result(nan_result),
      .invalid_flag(invalid_flag)
   );

   // operand patterns
   localparam logic [63:0] SQ  = 64'h7FC0_0001, SS  = 64'h7F80_0005, SI = 64'h7F80_0000;
   localparam logic [63:0] SQ2 = 64'hFFC1_2345, SS2 = 64'hFF80_0100, SONE = 64'h3F80_0000;
   localparam logic [63:0] DQ  = 64'h7FF8_0000_0000_0007, DS = 64'h7FF0_0000_0000_0009;
   localparam logic [63:0] DS2 = 64'hFFF0_0000_0001_0000, DONE = 64'h3FF0_0000_0000_0000;
   localparam logic [63:0] DI  = 64'h7FF0_0000_0000_0000;

   // 2 = quiet, 1 = signalling, 0 = not a NaN
   function automatic int nan_kind(logic [63:0] w, logic dbl);
      longint unsigned e, f, q;
      if (dbl) begin e = (w >> 52) & 64'h7FF; f = w & 64'hF_FFFF_FFFF_FFFF; q = (w >> 51) & 1;
         if (e != 64'h7FF || f == 0) return 0;
      end else begin e = (w >> 23) & 64'hFF; f = w & 64'h7F_FFFF; q = (w >> 22) & 1;
         if (e != 64'hFF || f == 0) return 0;
      end
      return (q != 0) ? 2 : 1;
   endfunction

   logic [63:0] exp_res; logic [1:0] exp_code; logic exp_inv; bit exp_valid;
   string exp_tag;

   task automatic model(input logic [63:0] a, b, c, input logic iz, input logic [1:0] pol,
                        input logic dbl, input logic dn);
      int k[3]; int ch; int ord_s[3]; int ord_q[3]; int last; logic [63:0] w[3];
      w[0] = a; w[1] = b; w[2] = c;
      for (int i = 0; i < 3; i++) k[i] = nan_kind(w[i], dbl);
      exp_inv = (k[0] == 1) || (k[1] == 1) || (k[2] == 1);
      exp_valid = (k[0] != 0) || (k[1] != 0) || (k[2] != 0);
      ch = -1;
      if (pol == 2'd2) begin
         if (iz) begin ch = 2; exp_inv = 1; end
         else if (k[0] != 0) ch = 0;
         else if (k[2] != 0) ch = 2;
         else ch = 1;
      end else begin
         if (pol == 2'd1) begin
            ord_s = '{0, 1, 2}; ord_q = '{0, 1, 2}; last = 2;
            if (iz) begin ch = 3; exp_inv = 1; end
         end else begin
            ord_s = '{2, 0, 1}; ord_q = '{2, 0, 1}; last = 1;
            if (iz && k[2] == 2) begin ch = 3; exp_inv = 1; end
         end
         for (int i = 0; i < 3 && ch < 0; i++) if (k[ord_s[i]] == 1) ch = ord_s[i];
         for (int i = 0; i < 2 && ch < 0; i++) if (k[ord_q[i]] == 2) ch = ord_q[i];
         if (ch < 0) ch = last;
      end
      exp_code = 2'(ch);
      if (dn || ch == 3) exp_res = dbl ? 64'h7FF8_0000_0000_0000 : 64'h7FC0_0000;
      else if (dbl) exp_res = w[ch] | 64'h0008_0000_0000_0000;
      else exp_res = (w[ch] & 64'hFFFF_FFFF) | 64'h40_0000;
   endtask

   task automatic check_now();
      total++;
      if (pick_code !== exp_code || nan_result !== exp_res || invalid_flag !== exp_inv) begin
         bad++;
         $display("FAIL %s: got code=%0d res=%h inv=%0b expected code=%0d res=%h inv=%0b",
                  exp_tag, pick_code, nan_result, invalid_flag, exp_code, exp_res, exp_inv);
      end
   endtask

   // drive one vector at negedge, compare at the next negedge (one register)
   task automatic run(input logic [63:0] a, b, c, input logic iz, input logic [1:0] pol,
                      input logic dbl, input logic dn, input string tag);
      op_a = a; op_b = b; op_c = c; prod_inf_zero = iz; policy_sel = pol;
      fmt_dbl = dbl; dflt_mode = dn;
      model(a, b, c, iz, pol, dbl, dn);
      exp_tag = tag;
      @(negedge clk);
      if (exp_valid) check_now();
   endtask

   function automatic logic [63:0] pick_pat(logic dbl);
      logic [63:0] r; int s = int'($urandom_range(0, 5));
      r = {$urandom, $urandom};
      if (dbl) case (s)
         0: return (r | DI) | 64'h0008_0000_0000_0000;
         1: return ((r & 64'h8007_FFFF_FFFF_FFFF) | DI) | 64'h1;
         2: return DONE;  3: return DI;  4: return 64'h0;  default: return r;
      endcase
      else case (s)
         0: return r | SI | 64'h40_0000;
         1: return ((r & 64'hFFFF_FFFF_803F_FFFF) | SI) | 64'h1;
         2: return SONE;  3: return SI;  4: return {r[63:32], 32'h0};  default: return r;
      endcase
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      exp_code = 0; exp_res = 0; exp_inv = 0; exp_tag = "R12 reset";
      check_now();
      rst_n = 1'b1;
      @(negedge clk);
      // policy 0
      run(SQ, SQ2, SS, 1'b0, 2'd0, 1'b0, 1'b0, "R4 c snan first");
      run(SS, SS2, SQ, 1'b0, 2'd0, 1'b0, 1'b0, "R4 a snan over b snan");
      run(SQ, SS2, SQ2, 1'b0, 2'd0, 1'b0, 1'b0, "R4 b snan over quiet");
      run(SQ, SQ2, SQ2, 1'b0, 2'd0, 1'b0, 1'b0, "R4 c quiet over a");
      run(SONE, SQ2, SONE, 1'b0, 2'd0, 1'b0, 1'b0, "R4 fallback b");
      run(SQ, SONE, SI, 1'b0, 2'd0, 1'b0, 1'b0, "R4 inf is not nan");
      run(SI, 64'h0, SQ, 1'b1, 2'd0, 1'b0, 1'b0, "R3 infzero quiet c");
      run(SI, 64'h0, SS, 1'b1, 2'd0, 1'b0, 1'b0, "R3 infzero signalling c");
      run(DS, DQ, DS2, 1'b0, 2'd3, 1'b1, 1'b0, "R11 spare code");
      // policy 1
      run(SQ, SS, SS2, 1'b0, 2'd1, 1'b0, 1'b0, "R6 b snan over c snan");
      run(SQ, SQ2, SS2, 1'b0, 2'd1, 1'b0, 1'b0, "R6 c snan over quiet");
      run(SONE, SQ2, SQ, 1'b0, 2'd1, 1'b0, 1'b0, "R6 b quiet over c");
      run(DI, 64'h0, DQ, 1'b1, 2'd1, 1'b1, 1'b0, "R5 infzero default");
      // policy 2
      run(SQ, SS, SONE, 1'b0, 2'd2, 1'b0, 1'b0, "R8 a any nan");
      run(SONE, SS, SQ2, 1'b0, 2'd2, 1'b0, 1'b0, "R8 c before b");
      run(DONE, DS, DONE, 1'b0, 2'd2, 1'b1, 1'b0, "R8 fallback b");
      run(DI, 64'h0, DS, 1'b1, 2'd2, 1'b1, 1'b0, "R7 infzero addend");
      // default mode, formats
      run(SS, SQ, SQ2, 1'b0, 2'd0, 1'b0, 1'b1, "R9 default single");
      run(DQ, DS, DQ, 1'b0, 2'd1, 1'b1, 1'b1, "R9 default double");
      run(64'hDEAD_BEEF_0000_0000 | SS, SONE | 64'hFFFF_FFFF_0000_0000, SONE, 1'b0, 2'd0,
          1'b0, 1'b0, "R10 upper bits ignored");
      run(64'h1234_5678_0000_0000 | SONE, SONE, SONE, 1'b0, 2'd0, 1'b0, 1'b0,
          "R10 upper nan-like ignored");
      run(DS2, DONE, DONE, 1'b0, 2'd0, 1'b1, 1'b0, "R1 double silenced");
      run(SS2, SONE, SONE, 1'b0, 2'd1, 1'b0, 1'b0, "R2 sign kept silenced");
      for (int n = 0; n < 600; n++) begin
         logic d; logic [1:0] p; logic [63:0] a, b, c;
         d = 1'($urandom); p = 2'($urandom);
         a = pick_pat(d); b = pick_pat(d); c = pick_pat(d);
         run(a, b, c, ($urandom_range(0, 7) == 0), p, d, ($urandom_range(0, 5) == 0),
             (p == 2'd1) ? "R6 random" : (p == 2'd2) ? "R8 random" : "R4 random");
      end
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog: got running expected finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule